// File: doc/BRIEF.md
# Single-Level Page Translator

This block turns a 16-bit virtual address into a 15-bit physical address through a small page map kept in registers. The map has one entry per virtual page (16 entries). Each entry holds a present flag and a 3-bit frame number. The top four address bits select the entry, and the low twelve bits are the byte offset within a 4096-byte page. When the selected entry is present, the frame number becomes the top of the physical address and the offset passes through unchanged. When the entry is absent, the block raises a page-fault trap that carries the faulting page number, and it produces no usable address.

Requests enter as a valid flag with an address. The answer comes back registered, exactly one clock later. Supervisor software fills the map through a write port, one entry per cycle. Each write names a page index, a present flag and a frame number, and it can install a mapping or withdraw one. Reset withdraws every mapping, so every access faults until software installs entries.

Top module: `pgx_translator`

## Requirements
- R1: For a present entry, `rsp_pa[14:12]` equals the entry's frame number and `rsp_pa[11:0]` equals `req_va[11:0]`. The page index is `req_va[15:12]`.
- R2: A response appears exactly one cycle after a cycle with `req_valid` high. In a cycle that follows no request, `rsp_valid` and `rsp_fault` are both 0.
- R3: A lookup of an entry whose present flag is 0 gives `rsp_fault`=1 and `rsp_valid`=0, with `rsp_pa`=0 and `rsp_fault_page` equal to `req_va[15:12]`.
- R4: After reset every entry is absent, so any lookup faults until a write installs that page. During reset both response flags are 0.
- R5: A map write takes effect for lookups issued in the next cycle onward. A lookup issued in the same cycle as a write to its page sees the entry as it was before the write.
- R6: A write with the present flag 0 withdraws a mapping, and later lookups anywhere in that page fault.
- R7: A write changes only the entry it names. Every other entry keeps its mapping.
- R8: `rsp_valid` and `rsp_fault` are never both 1. `rsp_fault_page` is 0 whenever `rsp_fault` is 0.
- R9: Worked mappings: page 0 to frame 2 maps VA 0 to PA 8192; page 2 to frame 6 maps VA 8192 to PA 24576; page 5 to frame 3 maps VA 20500 to PA 12308. After page 1 is withdrawn and page 8 is mapped to frame 1, VA 32780 maps to PA 4108 and VA 4096..8191 fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 16 | Virtual address to translate |
| wr_en | input | 1 | Map entry write strobe |
| wr_page | input | 4 | Page index of the entry to write |
| wr_present | input | 1 | Present flag to store |
| wr_frame | input | 3 | Frame number to store |
| rsp_valid | output | 1 | Translation succeeded, `rsp_pa` usable |
| rsp_pa | output | 15 | Physical address (0 unless `rsp_valid`) |
| rsp_fault | output | 1 | Page-fault trap for the request |
| rsp_fault_page | output | 4 | Page number that faulted |

## Verification
A corrupted present flag shows at the ports one cycle after the next lookup of that page, either as a fault where a mapping was installed or as an address where a fault was due. A corrupted frame number shows only in the top three bits of `rsp_pa`, and only on lookups of that page. For this reason the bench checks exact addresses on several pages, and it re-reads untouched pages after each write. A write that lands one cycle late or early is caught only by a lookup issued in the same cycle as the write, so that case is tested directly.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int unsigned DEF_VA_W       = 16;
  localparam int unsigned DEF_PAGE_BITS  = 4;
  localparam int unsigned DEF_FRAME_BITS = 3;
endpackage

// File: rtl/pgx_map_table.sv
module pgx_map_table #(
  parameter int unsigned PAGE_BITS  = pgx_pkg::DEF_PAGE_BITS,
  parameter int unsigned FRAME_BITS = pgx_pkg::DEF_FRAME_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [PAGE_BITS-1:0]  wr_page,
  input  logic                  wr_present,
  input  logic [FRAME_BITS-1:0] wr_frame,
  input  logic [PAGE_BITS-1:0]  rd_page,
  output logic                  rd_present,
  output logic [FRAME_BITS-1:0] rd_frame
);
  localparam int unsigned ENTRIES = 2 ** PAGE_BITS;

  // Present flags need reset, so they live in flops.
  // Frame numbers need no reset, so they can sit in distributed RAM.
  logic [ENTRIES-1:0]    present_q;
  logic [FRAME_BITS-1:0] frame_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      present_q <= '0;
    end else if (wr_en) begin
      present_q[wr_page] <= wr_present;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      frame_mem[wr_page] <= wr_frame;
    end
  end

  // Asynchronous read, so a lookup sees the contents from before any same-cycle write.
  assign rd_present = present_q[rd_page];
  assign rd_frame   = frame_mem[rd_page];
endmodule

// File: rtl/pgx_compose.sv
module pgx_compose #(
  parameter int unsigned VA_W       = pgx_pkg::DEF_VA_W,
  parameter int unsigned PAGE_BITS  = pgx_pkg::DEF_PAGE_BITS,
  parameter int unsigned FRAME_BITS = pgx_pkg::DEF_FRAME_BITS
) (
  input  logic                               req_valid,
  input  logic [VA_W-1:0]                    req_va,
  input  logic                               ent_present,
  input  logic [FRAME_BITS-1:0]              ent_frame,
  output logic                               nxt_valid,
  output logic                               nxt_fault,
  output logic [FRAME_BITS+VA_W-PAGE_BITS-1:0] nxt_pa,
  output logic [PAGE_BITS-1:0]               nxt_fault_page
);
  localparam int unsigned OFF_W = VA_W - PAGE_BITS;
  localparam int unsigned PA_W  = FRAME_BITS + OFF_W;

  logic [OFF_W-1:0]     offset;
  logic [PAGE_BITS-1:0] page;

  assign offset = req_va[OFF_W-1:0];
  assign page   = req_va[VA_W-1:OFF_W];

  always_comb begin
    nxt_valid      = 1'b0;
    nxt_fault      = 1'b0;
    nxt_pa         = '0;
    nxt_fault_page = '0;
    if (req_valid) begin
      if (ent_present) begin
        nxt_valid = 1'b1;
        nxt_pa    = PA_W'({ent_frame, offset});
      end else begin
        nxt_fault      = 1'b1;
        nxt_fault_page = page;
      end
    end
  end
endmodule

// File: rtl/pgx_resp_reg.sv
module pgx_resp_reg #(
  parameter int unsigned PA_W      = 15,
  parameter int unsigned PAGE_BITS = pgx_pkg::DEF_PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 d_valid,
  input  logic                 d_fault,
  input  logic [PA_W-1:0]      d_pa,
  input  logic [PAGE_BITS-1:0] d_fault_page,
  output logic                 q_valid,
  output logic                 q_fault,
  output logic [PA_W-1:0]      q_pa,
  output logic [PAGE_BITS-1:0] q_fault_page
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid      <= 1'b0;
      q_fault      <= 1'b0;
      q_pa         <= '0;
      q_fault_page <= '0;
    end else begin
      q_valid      <= d_valid;
      q_fault      <= d_fault;
      q_pa         <= d_pa;
      q_fault_page <= d_fault_page;
    end
  end
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator #(
  parameter int unsigned VA_W       = pgx_pkg::DEF_VA_W,
  parameter int unsigned PAGE_BITS  = pgx_pkg::DEF_PAGE_BITS,
  parameter int unsigned FRAME_BITS = pgx_pkg::DEF_FRAME_BITS,
  localparam int unsigned PA_W      = FRAME_BITS + VA_W - PAGE_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_va,
  input  logic                  wr_en,
  input  logic [PAGE_BITS-1:0]  wr_page,
  input  logic                  wr_present,
  input  logic [FRAME_BITS-1:0] wr_frame,
  output logic                  rsp_valid,
  output logic [PA_W-1:0]       rsp_pa,
  output logic                  rsp_fault,
  output logic [PAGE_BITS-1:0]  rsp_fault_page
);
  localparam int unsigned OFF_W = VA_W - PAGE_BITS;

  logic                  ent_present;
  logic [FRAME_BITS-1:0] ent_frame;
  logic                  nxt_valid;
  logic                  nxt_fault;
  logic [PA_W-1:0]       nxt_pa;
  logic [PAGE_BITS-1:0]  nxt_fault_page;

  pgx_map_table #(
    .PAGE_BITS (PAGE_BITS),
    .FRAME_BITS(FRAME_BITS)
  ) map_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_page   (wr_page),
    .wr_present(wr_present),
    .wr_frame  (wr_frame),
    .rd_page   (req_va[VA_W-1:OFF_W]),
    .rd_present(ent_present),
    .rd_frame  (ent_frame)
  );

  pgx_compose #(
    .VA_W      (VA_W),
    .PAGE_BITS (PAGE_BITS),
    .FRAME_BITS(FRAME_BITS)
  ) comp_i (
    .req_valid     (req_valid),
    .req_va        (req_va),
    .ent_present   (ent_present),
    .ent_frame     (ent_frame),
    .nxt_valid     (nxt_valid),
    .nxt_fault     (nxt_fault),
    .nxt_pa        (nxt_pa),
    .nxt_fault_page(nxt_fault_page)
  );

  pgx_resp_reg #(
    .PA_W     (PA_W),
    .PAGE_BITS(PAGE_BITS)
  ) resp_i (
    .clk         (clk),
    .rst         (rst),
    .d_valid     (nxt_valid),
    .d_fault     (nxt_fault),
    .d_pa        (nxt_pa),
    .d_fault_page(nxt_fault_page),
    .q_valid     (rsp_valid),
    .q_fault     (rsp_fault),
    .q_pa        (rsp_pa),
    .q_fault_page(rsp_fault_page)
  );
endmodule

// File: rtl/pgx_translator_chk.sv
module pgx_translator_chk #(
  parameter int unsigned VA_W       = 16,
  parameter int unsigned PAGE_BITS  = 4,
  parameter int unsigned FRAME_BITS = 3
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic                                  req_valid,
  input logic [VA_W-1:0]                       req_va,
  input logic                                  rsp_valid,
  input logic [FRAME_BITS+VA_W-PAGE_BITS-1:0]  rsp_pa,
  input logic                                  rsp_fault,
  input logic [PAGE_BITS-1:0]                  rsp_fault_page
);
  localparam int unsigned OFF_W = VA_W - PAGE_BITS;

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_fault));

  assert_fault_page_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !rsp_fault |-> rsp_fault_page == '0);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> !rsp_valid && !rsp_fault);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid || rsp_fault);

  assert_offset_passthru_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0]));

  assert_fault_page_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_fault_page == $past(req_va[VA_W-1:OFF_W]));

  assert_fault_no_addr_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_pa == '0);

  assert_reset_quiet_R4: assert property (@(posedge clk)
    $past(rst) |-> !rsp_valid && !rsp_fault);
endmodule

bind pgx_translator pgx_translator_chk #(
  .VA_W      (VA_W),
  .PAGE_BITS (PAGE_BITS),
  .FRAME_BITS(FRAME_BITS)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_va        (req_va),
  .rsp_valid     (rsp_valid),
  .rsp_pa        (rsp_pa),
  .rsp_fault     (rsp_fault),
  .rsp_fault_page(rsp_fault_page)
);

// File: tb/pgx_translator_tb_top.sv
`timescale 1ns/1ps
module pgx_translator_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_va = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_page = '0;
  logic        wr_present = 1'b0;
  logic [2:0]  wr_frame = '0;
  logic        rsp_valid;
  logic [14:0] rsp_pa;
  logic        rsp_fault;
  logic [3:0]  rsp_fault_page;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pgx_translator dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .wr_en(wr_en), .wr_page(wr_page), .wr_present(wr_present), .wr_frame(wr_frame),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_fault_page(rsp_fault_page)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic map_write(input int page, input bit pres, input int frame);
    @(negedge clk);
    wr_en = 1'b1; wr_page = 4'(page); wr_present = pres; wr_frame = 3'(frame);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issue one lookup. The response is registered on the following edge, so sample at the next negedge.
  task automatic lookup(input string tag, input int va, input bit exp_fault, input int exp_pa);
    @(negedge clk);
    req_valid = 1'b1; req_va = 16'(va);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, int'(rsp_valid), exp_fault ? 0 : 1);
    check({tag, " fault"}, int'(rsp_fault), exp_fault ? 1 : 0);
    check({tag, " pa"}, int'(rsp_pa), exp_fault ? 0 : exp_pa);
    check({tag, " fpage"}, int'(rsp_fault_page), exp_fault ? ((va >> 12) & 15) : 0);
  endtask

  task automatic t_reset_state();
    check("R4 reset rsp_valid", int'(rsp_valid), 0);
    check("R4 reset rsp_fault", int'(rsp_fault), 0);
    for (int p = 0; p < 16; p += 5) lookup("R4 post-reset fault", p * 4096 + 7, 1'b1, 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(negedge clk);
    check("R2 idle valid", int'(rsp_valid), 0);
    check("R2 idle fault", int'(rsp_fault), 0);
  endtask

  task automatic t_examples();
    map_write(0, 1'b1, 2);
    map_write(2, 1'b1, 6);
    map_write(5, 1'b1, 3);
    map_write(1, 1'b1, 1);
    lookup("R9 va0", 0, 1'b0, 8192);
    lookup("R9 va8192", 8192, 1'b0, 24576);
    lookup("R9 va20500", 20500, 1'b0, 12308);
    lookup("R1 offset top", 2 * 4096 + 4095, 1'b0, 6 * 4096 + 4095);
    lookup("R1 page1", 4096 + 100, 1'b0, 4096 + 100);
  endtask

  task automatic t_evict();
    map_write(1, 1'b0, 0);
    map_write(8, 1'b1, 1);
    lookup("R9 va32780", 32780, 1'b0, 4108);
    lookup("R6 page1 low", 4096, 1'b1, 0);
    lookup("R6 page1 high", 8191, 1'b1, 0);
    lookup("R7 page0 kept", 12, 1'b0, 8192 + 12);
    lookup("R7 page5 kept", 20500, 1'b0, 12308);
    lookup("R3 unmapped page15", 65535, 1'b1, 0);
  endtask

  task automatic t_same_cycle();
    // Write page 3 and look it up in the same cycle: the lookup must see the old (absent) entry.
    @(negedge clk);
    wr_en = 1'b1; wr_page = 4'd3; wr_present = 1'b1; wr_frame = 3'd5;
    req_valid = 1'b1; req_va = 16'(3 * 4096 + 33);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R5 same-cycle fault", int'(rsp_fault), 1);
    check("R5 same-cycle fpage", int'(rsp_fault_page), 3);
    lookup("R5 next-cycle hit", 3 * 4096 + 33, 1'b0, 5 * 4096 + 33);
    map_write(3, 1'b1, 7);
    lookup("R5 remap", 3 * 4096 + 1, 1'b0, 7 * 4096 + 1);
    lookup("R7 page2 kept", 8192, 1'b0, 24576);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_va = 16'd0;
    @(negedge clk);
    req_va = 16'(4096);
    check("R2 b2b first pa", int'(rsp_pa), 8192);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 b2b second fault", int'(rsp_fault), 1);
    check("R8 b2b excl", int'(rsp_valid & rsp_fault), 0);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    lookup("R4 re-reset page0", 0, 1'b1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_idle();
    t_examples();
    t_evict();
    t_same_cycle();
    t_back_to_back();
    t_reset_again();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule